// File: doc/BRIEF.md
# Hot-Plug Qualifier and Interrupt Controller

This block takes an asynchronous hot-plug-detect line, brings it into the clock domain, and qualifies it in two stages. A short-pulse rejector drops pulses of up to N cycles. A validity filter after it changes the qualified level only once a new level has lasted longer than M units of 1024 cycles. Edges of the qualified level, together with rising edges of a core interrupt line, a nonce-refresh line and a random-number error line, set sticky pending bits. Software can read, set and clear these bits. A per-source enable mask gates them into a single interrupt output.

Software reaches the block through a plain single-cycle register port. A write takes effect at the clock edge where `wrEn` is high. Reads are combinational from `addr`. Word addresses: 0 filter configuration, 1 enable mask, 2 pending status (write 1 to set), 3 pending clear (write 1 to clear, reads 0), 4 qualified level.

Top module: `hpd_irq_ctrl`

## Requirements
- R1: After reset the filter configuration, the mask, every pending bit, the qualified level and `irqOut` are all 0.
- R2: With glitch width N (configuration bits 15:12), a raw pulse lasting N cycles or fewer never reaches the qualified level, and a pulse of N+1 cycles does.
- R3: With validity width M (configuration bits 11:0), a level change lasting M*1024 cycles or fewer is rejected, and one lasting M*1024+1 cycles is accepted.
- R4: Bit 0 of address 4 reads the qualified hot-plug level.
- R5: A rise of the qualified level sets pending bit 1, and a fall sets pending bit 2.
- R6: Rising edges of `coreIrq`, `nonceRise` and `rndErr` set pending bits 0, 3 and 4. A line held high sets its bit only once.
- R7: Writing to address 2 sets each pending bit whose data bit is 1. Zero data bits leave pending bits unchanged.
- R8: Writing to address 3 clears each pending bit whose data bit is 1.
- R9: Bit 31 of address 2 reads the live level of `coreIrq`.
- R10: `irqOut` is the OR of the pending bits whose mask bit (address 1, bits 4:0, 1 = enabled) is set.
- R11: When a hardware event and a software clear hit the same bit in one cycle, the bit ends up set.
- R12: The filter configuration reads back as written in bits 15:0, and upper bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 3 | Register word address |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Combinational read data for `addr` |
| hpdRaw | input | 1 | Asynchronous raw hot-plug-detect line |
| coreIrq | input | 1 | Core interrupt level |
| nonceRise | input | 1 | Nonce-refresh event line |
| rndErr | input | 1 | Random-number error line |
| irqOut | output | 1 | Combined masked interrupt |

## Verification
The hot-plug path is driven with pulses one cycle either side of each threshold: N and N+1 cycles for the glitch stage, and 1024 and 1025 cycles for the validity stage with M=1. Each pair separates a `>=` comparison from a `>` comparison. A held level is also applied, so that the rise and fall bits can be told apart. Random sequences of software sets, clears, mask writes and event pulses check the pending word and `irqOut` against a bench model. A directed same-cycle event-plus-clear case shows that set wins over clear, and a held-high line shows edge rather than level sensitivity.

// File: rtl/hpd_irq_pkg.sv
package hpd_irq_pkg;
  localparam int NUM_SRC = 5;
  localparam int ADDR_W  = 3;

  localparam int SRC_CORE  = 0;
  localparam int SRC_RISE  = 1;
  localparam int SRC_FALL  = 2;
  localparam int SRC_NONCE = 3;
  localparam int SRC_RND   = 4;

  localparam logic [ADDR_W-1:0] ADDR_CFG   = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_MASK  = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_STAT  = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_CLR   = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_LEVEL = 3'd4;

  typedef struct packed {
    logic               cfgWr;
    logic               maskWr;
    logic [NUM_SRC-1:0] swSet;
    logic [NUM_SRC-1:0] swClr;
  } ctrlStb_t;
endpackage

// File: rtl/hpd_qual_stage.sv
module hpd_qual_stage #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             din,
  input  logic [CNT_W-1:0] thr,
  output logic             dout
);
  logic [CNT_W-1:0] cnt;

  // dout follows din only after thr+1 consecutive differing samples
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dout <= 1'b0;
      cnt  <= '0;
    end else if (din == dout) begin
      cnt <= '0;
    end else if (cnt >= thr) begin
      dout <= din;
      cnt  <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/hpd_reg_ctrl.sv
module hpd_reg_ctrl
  import hpd_irq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CFG_W  = 16
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [CFG_W-1:0]  cfg,
  input  logic [NUM_SRC-1:0] mask,
  input  logic [NUM_SRC-1:0] pend,
  input  logic              level,
  input  logic              coreIrq,
  output ctrlStb_t          stb,
  output logic [DATA_W-1:0] rdData
);
  logic unusedHi;
  assign unusedHi = ^wrData[DATA_W-1:CFG_W];

  always_comb begin
    stb        = '0;
    stb.cfgWr  = wrEn && (addr == ADDR_CFG);
    stb.maskWr = wrEn && (addr == ADDR_MASK);
    if (wrEn && addr == ADDR_STAT) stb.swSet = wrData[NUM_SRC-1:0];
    if (wrEn && addr == ADDR_CLR)  stb.swClr = wrData[NUM_SRC-1:0];
  end

  always_comb begin
    rdData = '0;
    case (addr)
      ADDR_CFG:   rdData[CFG_W-1:0] = cfg;
      ADDR_MASK:  rdData[NUM_SRC-1:0] = mask;
      ADDR_STAT: begin
        rdData[NUM_SRC-1:0] = pend;
        rdData[DATA_W-1]    = coreIrq;
      end
      ADDR_LEVEL: rdData[0] = level;
      default:    rdData = '0;
    endcase
  end
endmodule

// File: rtl/hpd_datapath.sv
module hpd_datapath
  import hpd_irq_pkg::*;
#(
  parameter int GLITCH_W  = 4,
  parameter int VALID_W   = 12,
  parameter int UNIT_LOG2 = 10,
  parameter int SYNC_N    = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ctrlStb_t                      stb,
  input  logic [GLITCH_W+VALID_W-1:0]   cfgIn,
  input  logic [NUM_SRC-1:0]            maskIn,
  input  logic                          hpdRaw,
  input  logic                          coreIrq,
  input  logic                          nonceRise,
  input  logic                          rndErr,
  output logic [GLITCH_W+VALID_W-1:0]   cfg,
  output logic [NUM_SRC-1:0]            mask,
  output logic [NUM_SRC-1:0]            pend,
  output logic [NUM_SRC-1:0]            evt,
  output logic                          level,
  output logic                          irqOut
);
  localparam int VCNT_W = VALID_W + UNIT_LOG2;

  logic [SYNC_N-1:0] syncQ;
  logic              deglitched;
  logic              levelPrev, corePrev, noncePrev, rndPrev;
  logic [GLITCH_W-1:0] glitchThr;
  logic [VCNT_W-1:0]   validThr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_N-2:0], hpdRaw};
  end

  assign glitchThr = cfg[GLITCH_W+VALID_W-1:VALID_W];
  assign validThr  = {cfg[VALID_W-1:0], {UNIT_LOG2{1'b0}}};

  hpd_qual_stage #(.CNT_W(GLITCH_W)) u_glitch (
    .clk(clk), .rstN(rstN), .din(syncQ[SYNC_N-1]), .thr(glitchThr), .dout(deglitched)
  );

  hpd_qual_stage #(.CNT_W(VCNT_W)) u_valid (
    .clk(clk), .rstN(rstN), .din(deglitched), .thr(validThr), .dout(level)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      levelPrev <= 1'b0;
      corePrev  <= 1'b0;
      noncePrev <= 1'b0;
      rndPrev   <= 1'b0;
    end else begin
      levelPrev <= level;
      corePrev  <= coreIrq;
      noncePrev <= nonceRise;
      rndPrev   <= rndErr;
    end
  end

  always_comb begin
    evt            = '0;
    evt[SRC_CORE]  = coreIrq & ~corePrev;
    evt[SRC_RISE]  = level & ~levelPrev;
    evt[SRC_FALL]  = ~level & levelPrev;
    evt[SRC_NONCE] = nonceRise & ~noncePrev;
    evt[SRC_RND]   = rndErr & ~rndPrev;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg  <= '0;
      mask <= '0;
      pend <= '0;
    end else begin
      if (stb.cfgWr)  cfg  <= cfgIn;
      if (stb.maskWr) mask <= maskIn;
      pend <= (pend & ~stb.swClr) | stb.swSet | evt;
    end
  end

  assign irqOut = |(pend & mask);
endmodule

// File: rtl/hpd_irq_ctrl.sv
module hpd_irq_ctrl
  import hpd_irq_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int GLITCH_W  = 4,
  parameter int VALID_W   = 12,
  parameter int UNIT_LOG2 = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              hpdRaw,
  input  logic              coreIrq,
  input  logic              nonceRise,
  input  logic              rndErr,
  output logic              irqOut
);
  localparam int CFG_W = GLITCH_W + VALID_W;

  ctrlStb_t           stb;
  logic [CFG_W-1:0]   cfg;
  logic [NUM_SRC-1:0] mask, pend, evt;
  logic               level;

  hpd_reg_ctrl #(.DATA_W(DATA_W), .CFG_W(CFG_W)) u_ctrl (
    .wrEn(wrEn), .addr(addr), .wrData(wrData), .cfg(cfg), .mask(mask),
    .pend(pend), .level(level), .coreIrq(coreIrq), .stb(stb), .rdData(rdData)
  );

  hpd_datapath #(.GLITCH_W(GLITCH_W), .VALID_W(VALID_W), .UNIT_LOG2(UNIT_LOG2)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .cfgIn(wrData[CFG_W-1:0]),
    .maskIn(wrData[NUM_SRC-1:0]), .hpdRaw(hpdRaw), .coreIrq(coreIrq),
    .nonceRise(nonceRise), .rndErr(rndErr), .cfg(cfg), .mask(mask),
    .pend(pend), .evt(evt), .level(level), .irqOut(irqOut)
  );
endmodule

// File: rtl/hpd_irq_ctrl_chk.sv
module hpd_irq_ctrl_chk
  import hpd_irq_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               wrEn,
  input logic [ADDR_W-1:0]  addr,
  input logic [NUM_SRC-1:0] wrLow,
  input logic               rdTop,
  input logic               coreIrq,
  input logic               irqOut,
  input logic [NUM_SRC-1:0] pend,
  input logic [NUM_SRC-1:0] mask,
  input logic [NUM_SRC-1:0] evt
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rstN |=> (pend == '0 && mask == '0 && !irqOut));

  assert_sw_set_R7: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_STAT) |=> ((pend & $past(wrLow)) == $past(wrLow)));

  assert_sw_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_CLR) |=> ((pend & $past(wrLow) & ~$past(evt)) == '0));

  assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rstN)
    (|evt) |=> ((pend & $past(evt)) == $past(evt)));

  assert_masked_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    (mask == '0) |-> !irqOut);

  assert_live_core_R9: assert property (@(posedge clk) disable iff (!rstN)
    (addr == ADDR_STAT) |-> (rdTop == coreIrq));
endmodule

bind hpd_irq_ctrl hpd_irq_ctrl_chk u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
  .wrLow(wrData[hpd_irq_pkg::NUM_SRC-1:0]), .rdTop(rdData[DATA_W-1]),
  .coreIrq(coreIrq), .irqOut(irqOut), .pend(pend), .mask(mask), .evt(evt)
);

// File: tb/hpd_irq_ctrl_test.sv
`timescale 1ns/1ps
module hpd_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        hpdRaw = 1'b0, coreIrq = 1'b0, nonceRise = 1'b0, rndErr = 1'b0;
  logic        irqOut;

  int runCnt = 0;
  int failCnt = 0;
  logic [4:0] mPend = '0;
  logic [4:0] mMask = '0;

  always #4 clk = ~clk;

  hpd_irq_ctrl uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .hpdRaw(hpdRaw), .coreIrq(coreIrq),
    .nonceRise(nonceRise), .rndErr(rndErr), .irqOut(irqOut)
  );

  function automatic logic expIrq(logic [4:0] p, logic [4:0] m);
    return |(p & m);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    runCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wrReg(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic rdReg(logic [2:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdData;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic hpdPulse(int len);
    @(negedge clk);
    hpdRaw = 1'b1;
    idle(len);
    hpdRaw = 1'b0;
  endtask

  initial begin
    #(8ns * 150000);
    failCnt++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", runCnt, failCnt);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd1234));
    idle(3);
    rstN = 1'b1;
    idle(2);

    // R1: reset state
    rdReg(3'd0, d); check("R1 cfg", d, 32'h0);
    rdReg(3'd1, d); check("R1 mask", d, 32'h0);
    rdReg(3'd2, d); check("R1 status", d, 32'h0);
    rdReg(3'd4, d); check("R1 level", d, 32'h0);
    check("R1 irqOut", {31'b0, irqOut}, 32'h0);

    // R12: configuration readback
    wrReg(3'd0, 32'hFFFF_ABCD);
    rdReg(3'd0, d); check("R12 cfg readback", d, 32'h0000_ABCD);
    wrReg(3'd0, 32'h0000_3000);
    rdReg(3'd0, d); check("R12 cfg N=3", d, 32'h0000_3000);

    // R2: glitch stage at N=3
    hpdPulse(3); idle(20);
    rdReg(3'd2, d); check("R2 pulse of N rejected", d, 32'h0);
    hpdPulse(4); idle(20);
    rdReg(3'd2, d); check("R2 pulse of N+1 accepted", d, 32'h6);
    wrReg(3'd3, 32'h6);
    rdReg(3'd2, d); check("R8 clear hot-plug bits", d, 32'h0);

    // R4, R5: held level
    @(negedge clk); hpdRaw = 1'b1; idle(20);
    rdReg(3'd4, d); check("R4 level high", d, 32'h1);
    rdReg(3'd2, d); check("R5 rise only", d, 32'h2);
    hpdRaw = 1'b0; idle(20);
    rdReg(3'd4, d); check("R4 level low", d, 32'h0);
    rdReg(3'd2, d); check("R5 rise and fall", d, 32'h6);
    wrReg(3'd3, 32'h1F);

    // R3: validity stage at M=1, N=0
    wrReg(3'd0, 32'h0000_0001);
    hpdPulse(1024); idle(30);
    rdReg(3'd2, d); check("R3 width M*1024 rejected", d, 32'h0);
    hpdPulse(1025); idle(10);
    rdReg(3'd4, d); check("R3 level accepted", d, 32'h1);
    idle(1100);
    rdReg(3'd2, d); check("R3 width M*1024+1 accepted", d, 32'h6);
    wrReg(3'd3, 32'h1F);
    wrReg(3'd0, 32'h0);

    // R9: live core level, and R6 edge on it
    @(negedge clk); coreIrq = 1'b1; idle(2);
    rdReg(3'd2, d); check("R9 live core high, R6 core edge", d, 32'h8000_0001);
    coreIrq = 1'b0; idle(1);
    rdReg(3'd2, d); check("R9 live core low", d, 32'h1);
    wrReg(3'd3, 32'h1);

    // R6: held line sets once
    @(negedge clk); rndErr = 1'b1; idle(2);
    wrReg(3'd3, 32'h10); idle(3);
    rdReg(3'd2, d); check("R6 held line no re-set", d, 32'h0);
    rndErr = 1'b0; idle(1);

    // R7: zero write no effect, one sets
    wrReg(3'd2, 32'h0);
    rdReg(3'd2, d); check("R7 zero write", d, 32'h0);
    wrReg(3'd2, 32'h8);
    rdReg(3'd2, d); check("R7 set bit 3", d, 32'h8);

    // R11: event and clear together, after clearing
    wrReg(3'd3, 32'h8);
    @(negedge clk);
    nonceRise = 1'b1; wrEn = 1'b1; addr = 3'd3; wrData = 32'h8;
    @(negedge clk);
    nonceRise = 1'b0; wrEn = 1'b0; wrData = '0;
    rdReg(3'd2, d); check("R11 set wins", d, 32'h8);
    wrReg(3'd3, 32'h1F);
    mPend = '0;

    // R10 with R6/R7/R8: random mix
    for (int i = 0; i < 300; i++) begin
      int op;
      logic [4:0] v;
      op = int'($urandom_range(0, 3));
      v = 5'($urandom);
      case (op)
        0: begin wrReg(3'd2, {27'b0, v}); mPend = mPend | v; end
        1: begin wrReg(3'd3, {27'b0, v}); mPend = mPend & ~v; end
        2: begin wrReg(3'd1, {27'b0, v}); mMask = v; end
        default: begin
          int s;
          s = int'($urandom_range(0, 2));
          @(negedge clk);
          if (s == 0) coreIrq = 1'b1; else if (s == 1) nonceRise = 1'b1; else rndErr = 1'b1;
          @(negedge clk);
          coreIrq = 1'b0; nonceRise = 1'b0; rndErr = 1'b0;
          mPend[(s == 0) ? 0 : (s == 1) ? 3 : 4] = 1'b1;
          @(negedge clk);
        end
      endcase
      rdReg(3'd2, d); check("R6/R7/R8 random pending", d, {27'b0, mPend});
      check("R10 random irqOut", {31'b0, irqOut}, {31'b0, expIrq(mPend, mMask)});
    end
    rdReg(3'd1, d); check("R10 mask readback", d, {27'b0, mMask});

    $display("[TB] %0d tests run, %0d failed", runCnt, failCnt);
    $finish;
  end
endmodule